// File: doc/BRIEF.md
# Dual Timer/Counter

This block holds two identical 16-bit timer/counter channels. Each channel keeps a low and a high count byte and takes its setup from one nibble of a shared mode register. A channel can count every clock cycle or count falling edges on its own external count pin. It can also be gated so that it counts only while a matching gate pin is high. Each channel has three operating modes and one reserved code:

- a 13-bit timer with a 5-bit prescaler in the low byte;
- a full 16-bit timer;
- an 8-bit counter that reloads from the high byte.

When a channel overflows, it sets its own overflow flag. This flag drives an interrupt request.

A processor uses a simple register port to program the block. Through that port it writes the mode register, the run bits, the flags and the four count bytes, and it reads them back. Each channel has a vector-acknowledge input. Pulsing it when that channel's interrupt is taken clears the flag.

Top module: `dual_tmr_ctr`

## Requirements
- R1: After reset every register reads 0. Address 1 holds the mode register. Bits 7:4 configure channel 1 and bits 3:0 configure channel 0, each nibble ordered gate (MSB), external-count select, mode high, mode low (LSB).
- R2: Address 0 reads run0 at bit 0, run1 at bit 1, flag0 at bit 4 and flag1 at bit 5, with other bits 0. Addresses 2/3 hold channel 0 low/high bytes and 4/5 hold channel 1 low/high bytes. Other addresses read 0, and rdata follows addr combinationally.
- R3: Mode code 01 treats {high,low} as one 16-bit counter. A step from FFFFh wraps to 0000h and sets the flag.
- R4: Mode code 00 increments low bits 4:0 as a prescaler and leaves low bits 7:5 unchanged. A prescaler wrap increments the high byte, and a high-byte wrap from FFh sets the flag.
- R5: Mode code 10 increments the low byte. A step from FFh loads the low byte with the high byte and sets the flag, and the high byte never changes.
- R6: Mode code 11 holds both count bytes and never sets the flag.
- R7: A channel steps only while its run bit is 1 and either its gate bit is 0 or its gate pin is high. Otherwise its count holds.
- R8: With external-count select at 0, a channel steps every clock. With it at 1, the channel steps once per falling edge of its count pin: if the pin is sampled high at edge k and low at edge k+1, the step happens at edge k+3.
- R9: The overflow flag is set by overflow. A control write (address 0) sets or clears it. A vec_ack pulse clears it when there is no write and no overflow in that cycle.
- R10: A write to either count byte of a channel loads that byte and cancels that channel's step in the same cycle. The other byte holds.
- R11: An overflow in the same cycle as a control write or acknowledge leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| vec_ack | input | 2 | Per-channel interrupt vector acknowledge |
| cnt_pin | input | 2 | Per-channel external count pin |
| gate_pin | input | 2 | Per-channel gate pin |
| ovf_flag | output | 2 | Per-channel overflow flag |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 5-bit prescaler and a two-flop count-pin synchroniser. With these values, an overflow in every mode is reached within a few cycles by preloading count bytes next to their wrap points. An 8-bit reload from FFh with a high byte of FFh gives an overflow on every step. This lets control writes and acknowledges collide with hardware overflows deliberately. A behavioural model tracks the pin history and per-mode counting, and it checks the read port and the flags on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NUM_CH  = 2;
    localparam int NIB_W   = 4;

    // Positions inside one channel nibble
    localparam int CFG_GATE = 3;
    localparam int CFG_EXT  = 2;

    typedef enum logic [1:0] {
        MD_PRESCALE13 = 2'b00,
        MD_FULL16     = 2'b01,
        MD_RELOAD8    = 2'b10,
        MD_RESERVED   = 2'b11
    } tmr_mode_e;

endpackage

// File: rtl/tmr_fall_det.sv
module tmr_fall_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], pin_i};
    end

    // Oldest synchronised sample high, next one low
    assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int PRE_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  cfg_i,
    input  logic              run_i,
    input  logic              gate_pin_i,
    input  logic              ext_fall_i,
    input  logic              sw_lo_we_i,
    input  logic              sw_hi_we_i,
    input  logic              sw_flag_we_i,
    input  logic              sw_flag_val_i,
    input  logic [DATA_W-1:0] sw_data_i,
    input  logic              vec_ack_i,
    output logic [DATA_W-1:0] lo_o,
    output logic [DATA_W-1:0] hi_o,
    output logic              flag_o,
    output logic              ovf_o
);
    localparam int SUM_W = 2 * DATA_W + 1;

    tmr_mode_e         mode;
    logic              enabled, tick, step;
    logic [DATA_W-1:0] lo_q, hi_q, lo_n, hi_n;
    logic              flag_q, flag_n, ovf;
    logic [SUM_W-1:0]  sum;

    assign mode    = tmr_mode_e'(cfg_i[1:0]);
    assign enabled = run_i && (!cfg_i[CFG_GATE] || gate_pin_i);
    assign tick    = cfg_i[CFG_EXT] ? ext_fall_i : 1'b1;
    assign step    = enabled && tick && !(sw_lo_we_i || sw_hi_we_i);
    assign sum     = {1'b0, hi_q, lo_q} + 1'b1;

    always_comb begin
        lo_n = lo_q;
        hi_n = hi_q;
        ovf  = 1'b0;
        unique case (mode)
            MD_PRESCALE13: begin
                if (step) begin
                    if (&lo_q[PRE_BITS-1:0]) begin
                        lo_n[PRE_BITS-1:0] = '0;
                        hi_n = hi_q + 1'b1;
                        ovf  = &hi_q;
                    end else begin
                        lo_n[PRE_BITS-1:0] = lo_q[PRE_BITS-1:0] + 1'b1;
                    end
                end
            end
            MD_FULL16: begin
                if (step) begin
                    {hi_n, lo_n} = sum[SUM_W-2:0];
                    ovf = sum[SUM_W-1];
                end
            end
            MD_RELOAD8: begin
                if (step) begin
                    if (&lo_q) begin
                        lo_n = hi_q;
                        ovf  = 1'b1;
                    end else begin
                        lo_n = lo_q + 1'b1;
                    end
                end
            end
            MD_RESERVED: begin
                lo_n = lo_q;
            end
        endcase
        if (sw_lo_we_i) lo_n = sw_data_i;
        if (sw_hi_we_i) hi_n = sw_data_i;
    end

    always_comb begin
        if (ovf)               flag_n = 1'b1;
        else if (sw_flag_we_i) flag_n = sw_flag_val_i;
        else if (vec_ack_i)    flag_n = 1'b0;
        else                   flag_n = flag_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            flag_q <= 1'b0;
        end else begin
            lo_q   <= lo_n;
            hi_q   <= hi_n;
            flag_q <= flag_n;
        end
    end

    assign lo_o   = lo_q;
    assign hi_o   = hi_q;
    assign flag_o = flag_q;
    assign ovf_o  = ovf;
endmodule

// File: rtl/dual_tmr_ctr.sv
module dual_tmr_ctr
    import tmr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int PRE_BITS    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [1:0]        vec_ack,
    input  logic [1:0]        cnt_pin,
    input  logic [1:0]        gate_pin,
    output logic [1:0]        ovf_flag
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(1);
    localparam int CNT_BASE  = 2;
    localparam int RUN_BIT0  = 0;
    localparam int FLAG_BIT0 = 4;

    logic [DATA_W-1:0]             mode_q;
    logic [NUM_CH-1:0]             run_q;
    logic [NUM_CH-1:0]             ovf_pulse;
    logic [NUM_CH-1:0]             fall;
    logic [NUM_CH-1:0][DATA_W-1:0] cnt_lo, cnt_hi;
    logic                          ctrl_we;

    assign ctrl_we = wr_en && (addr == A_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            run_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_MODE) mode_q <= wdata;
            if (addr == A_CTRL) run_q  <= wdata[RUN_BIT0 +: NUM_CH];
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(CNT_BASE + 2 * i);
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(CNT_BASE + 2 * i + 1);

        tmr_fall_det #(.STAGES(SYNC_STAGES)) u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (cnt_pin[i]),
            .fall_o (fall[i])
        );

        tmr_channel #(.DATA_W(DATA_W), .PRE_BITS(PRE_BITS)) u_ch (
            .clk           (clk),
            .rst_n         (rst_n),
            .cfg_i         (mode_q[NIB_W*i +: NIB_W]),
            .run_i         (run_q[i]),
            .gate_pin_i    (gate_pin[i]),
            .ext_fall_i    (fall[i]),
            .sw_lo_we_i    (wr_en && (addr == LO_A)),
            .sw_hi_we_i    (wr_en && (addr == HI_A)),
            .sw_flag_we_i  (ctrl_we),
            .sw_flag_val_i (wdata[FLAG_BIT0 + i]),
            .sw_data_i     (wdata),
            .vec_ack_i     (vec_ack[i]),
            .lo_o          (cnt_lo[i]),
            .hi_o          (cnt_hi[i]),
            .flag_o        (ovf_flag[i]),
            .ovf_o         (ovf_pulse[i])
        );
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata[RUN_BIT0 +: NUM_CH]  = run_q;
            rdata[FLAG_BIT0 +: NUM_CH] = ovf_flag;
        end else if (addr == A_MODE) begin
            rdata = mode_q;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(CNT_BASE + 2 * i))     rdata = cnt_lo[i];
            if (addr == ADDR_W'(CNT_BASE + 2 * i + 1)) rdata = cnt_hi[i];
        end
    end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [AW-1:0]     addr,
    input logic [DW-1:0]     wdata,
    input logic [1:0]        vec_ack,
    input logic [1:0]        run_q,
    input logic [DW-1:0]     mode_q,
    input logic [1:0]        ovf_pulse,
    input logic [1:0]        ovf_flag,
    input logic [1:0][DW-1:0] cnt_lo,
    input logic [1:0][DW-1:0] cnt_hi
);
    logic ctrl_wr, ch0_cnt_wr;
    assign ctrl_wr    = wr_en && (addr == AW'(0));
    assign ch0_cnt_wr = wr_en && (addr == AW'(2) || addr == AW'(3));

    // R1
    mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(1)) |=> (mode_q == $past(wdata)));

    // R11
    ovf_wins0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse[0] |=> ovf_flag[0]);

    // R11
    ovf_wins1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse[1] |=> ovf_flag[1]);

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack[0] && !ovf_pulse[0] && !ctrl_wr) |=> !ovf_flag[0]);

    // R6
    reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1:0] == 2'b11 && !ch0_cnt_wr) |=> $stable({cnt_hi[0], cnt_lo[0]}));

    // R6
    reserved_noovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1:0] == 2'b11) |-> !ovf_pulse[0]);

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_pulse[0] && mode_q[1:0] == 2'b10 && !ch0_cnt_wr)
            |=> (cnt_lo[0] == $past(cnt_hi[0])));

    // R7
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q[0] && !ch0_cnt_wr) |=> $stable({cnt_hi[0], cnt_lo[0]}));
endmodule

bind dual_tmr_ctr tmr_chk #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .vec_ack   (vec_ack),
    .run_q     (run_q),
    .mode_q    (mode_q),
    .ovf_pulse (ovf_pulse),
    .ovf_flag  (ovf_flag),
    .cnt_lo    (cnt_lo),
    .cnt_hi    (cnt_hi)
);

// File: tb/tb_dual_tmr_ctr.sv
`timescale 1ns/1ps
module tb_dual_tmr_ctr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] vec_ack = '0;
    logic [1:0] cnt_pin = '0;
    logic [1:0] gate_pin = '0;
    logic [1:0] ovf_flag;

    always #10 clk = ~clk;

    dual_tmr_ctr dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .vec_ack(vec_ack), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .ovf_flag(ovf_flag)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_on = 0;
    bit done = 0;

    // Behavioural reference model
    int       m_lo [2] = '{0, 0};
    int       m_hi [2] = '{0, 0};
    bit       m_flag [2] = '{0, 0};
    bit [7:0] m_mode = '0;
    bit [1:0] m_run = '0;
    bit [3:0] m_hist [2] = '{4'b0, 4'b0};

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int m_read(input int a);
        case (a)
            0: return m_run[0] + 2 * m_run[1] + 16 * m_flag[0] + 32 * m_flag[1];
            1: return m_mode;
            2: return m_lo[0];
            3: return m_hi[0];
            4: return m_lo[1];
            5: return m_hi[1];
            default: return 0;
        endcase
    endfunction

    task automatic model_step();
        bit [7:0] nmode = m_mode;
        bit [1:0] nrun = m_run;
        for (int i = 0; i < 2; i++) begin
            bit [3:0] nib = m_mode[4*i +: 4];
            bit en   = m_run[i] && (!nib[3] || gate_pin[i]);
            bit fl   = m_hist[i][2] && !m_hist[i][1];
            bit tk   = nib[2] ? fl : 1'b1;
            bit wlo  = wr_en && addr == 3'(2 + 2*i);
            bit whi  = wr_en && addr == 3'(3 + 2*i);
            bit go   = en && tk && !(wlo || whi);
            bit ov   = 0;
            int lo   = m_lo[i];
            int hi   = m_hi[i];
            if (go) begin
                case (nib[1:0])
                    2'b00: begin
                        if (lo % 32 == 31) begin
                            lo = lo - 31;
                            if (hi == 255) begin hi = 0; ov = 1; end
                            else hi = hi + 1;
                        end else lo = lo + 1;
                    end
                    2'b01: begin
                        int v = hi * 256 + lo + 1;
                        if (v == 65536) begin v = 0; ov = 1; end
                        hi = v / 256;
                        lo = v % 256;
                    end
                    2'b10: begin
                        if (lo == 255) begin lo = m_hi[i]; ov = 1; end
                        else lo = lo + 1;
                    end
                    default: ;
                endcase
            end
            if (wlo) lo = wdata;
            if (whi) hi = wdata;
            if (ov) m_flag[i] = 1;
            else if (wr_en && addr == 3'd0) m_flag[i] = wdata[4+i];
            else if (vec_ack[i]) m_flag[i] = 0;
            m_lo[i] = lo;
            m_hi[i] = hi;
            m_hist[i] = {m_hist[i][2:0], cnt_pin[i]};
        end
        if (wr_en && addr == 3'd1) nmode = wdata;
        if (wr_en && addr == 3'd0) nrun = wdata[1:0];
        m_mode = nmode;
        m_run = nrun;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = '{0, 0}; m_hi = '{0, 0}; m_flag = '{0, 0};
            m_mode = '0; m_run = '0; m_hist = '{4'b0, 4'b0};
        end else begin
            model_step();
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check("R2 rdata", rdata, m_read(addr));
            check("R9 flags", ovf_flag, m_flag[0] + 2 * m_flag[1]);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); #2;
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); #2;
        addr = a;
        #1 v = rdata;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        idle(3);
        #2 rst_n = 1'b1;
        cmp_on = 1;

        // R1, R2 reset contents
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset value", v, 0);
        end

        // R1 mode register write and readback
        wr(3'd1, 8'hA5);
        rd(3'd1, v); check("R1 mode readback", v, 8'hA5);

        // R3 16-bit wrap on channel 0
        wr(3'd1, 8'h01);
        wr(3'd2, 8'hFD); wr(3'd3, 8'hFF);
        wr(3'd0, 8'h01);
        idle(8);
        rd(3'd0, v); check("R3 flag0 after wrap", v[4], 1);
        wr(3'd0, 8'h10);
        rd(3'd3, v); check("R3 high byte wrapped", v, 0);

        // R9 acknowledge clears flag
        rd(3'd0, v); check("R9 flag0 written", v, 8'h10);
        @(negedge clk); #2 vec_ack = 2'b01;
        @(negedge clk); #2 vec_ack = 2'b00;
        rd(3'd0, v); check("R9 ack cleared", v, 0);

        // R6 reserved mode holds
        wr(3'd1, 8'h03);
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        wr(3'd0, 8'h01);
        idle(20);
        wr(3'd0, 8'h00);
        rd(3'd2, v); check("R6 low held", v, 8'hFF);
        rd(3'd3, v); check("R6 high held", v, 8'hFF);
        rd(3'd0, v); check("R6 no flag", v, 0);

        // R4 13-bit prescaler mode
        wr(3'd1, 8'h00);
        wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
        wr(3'd0, 8'h01);
        idle(6);
        rd(3'd0, v); check("R4 flag0 set", v[4], 1);
        wr(3'd0, 8'h00);
        rd(3'd3, v); check("R4 high byte wrapped", v, 0);
        rd(3'd2, v); check("R4 low bits 7:5 kept", v[7:5], 3'b111);

        // R5 reload mode
        wr(3'd1, 8'h02);
        wr(3'd3, 8'hF0); wr(3'd2, 8'hFC);
        wr(3'd0, 8'h01);
        idle(8);
        rd(3'd0, v); check("R5 flag0 set", v[4], 1);
        wr(3'd0, 8'h00);
        rd(3'd3, v); check("R5 high unchanged", v, 8'hF0);
        rd(3'd2, v); check("R5 low reloaded", (v >= 8'hF0 && v < 8'hFC) ? 1 : 0, 1);

        // R11 overflow every step beats flag-clearing write; R10 write wins
        wr(3'd3, 8'hFF); wr(3'd2, 8'hFF);
        wr(3'd0, 8'h01);
        idle(3);
        wr(3'd0, 8'h01);
        rd(3'd0, v); check("R11 flag kept by overflow", v[4], 1);
        wr(3'd2, 8'h00);
        #1 check("R10 count write beats reload", rdata, 0);
        wr(3'd0, 8'h00);
        rd(3'd0, v); check("R9 flag cleared by write", v, 0);

        // R7 gating
        wr(3'd1, 8'h09);
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        gate_pin = 2'b00;
        wr(3'd0, 8'h01);
        idle(10);
        rd(3'd2, v); check("R7 gated low holds", v, 0);
        @(negedge clk); #2 gate_pin = 2'b01;
        idle(5);
        @(negedge clk); #2 gate_pin = 2'b00;
        wr(3'd0, 8'h00);
        rd(3'd2, v); check("R7 counted while gate high", (v != 0) ? 1 : 0, 1);

        // R8 external falling edges
        wr(3'd1, 8'h05);
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd0, 8'h01);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); #2 cnt_pin[0] = 1'b1;
            idle(4);
            @(negedge clk); #2 cnt_pin[0] = 1'b0;
            idle(4);
        end
        idle(4);
        wr(3'd0, 8'h00);
        rd(3'd2, v); check("R8 one step per fall", v, 5);

        // R3 on channel 1, channel 0 left alone
        wr(3'd1, 8'h10);
        wr(3'd4, 8'hFE); wr(3'd5, 8'hFF);
        wr(3'd0, 8'h02);
        idle(6);
        rd(3'd0, v); check("R3 flag1 after wrap", v[5], 1);
        rd(3'd2, v); check("R7 channel 0 idle holds", v, 5);
        wr(3'd0, 8'h00);
        idle(2);

        finish_run();
    end
endmodule